// File: doc/BRIEF.md
# EEPROM Self-Timed Write Cycle Controller

This block sits between the serial bus front end of a small EEPROM and its storage array. The front end reports three events: a write command has been accepted and carries a word address, a data byte has been received and acknowledged, and a STOP has been seen. The block gathers the data bytes in a one-page buffer. When a STOP closes a write command that delivered at least one byte, and write protect is low, it starts a timed programming cycle. That cycle lasts a fixed number of system clock ticks.

While the cycle runs, the block raises a busy flag. During that time it ignores every event from the front end and forces the device-address acknowledge low, so a controller can poll for completion. At the start of the cycle the buffered bytes are copied into the array as a burst of single-cycle writes. When the tick count expires the block returns to standby with an empty buffer. If write protect is high at the STOP, the buffered bytes are dropped and no cycle starts.

Top module: `eeprom_wr_cycle_ctrl`

## Requirements
- R1: After reset `busy_o` is low, `arr_we_o` is low and the page buffer holds no bytes.
- R2: A STOP sampled in standby, with at least one buffered byte and `wp_i` low, sets `busy_o` high from the next cycle. `busy_o` then stays high for exactly `WR_TICKS` cycles and returns low.
- R3: A STOP with no buffered byte starts no cycle and writes nothing. This covers a write command that only loaded an address and a STOP with no command before it.
- R4: If `wp_i` is high when the STOP is sampled, nothing is written, `busy_o` stays low and the buffered bytes are discarded. A later STOP therefore starts no cycle.
- R5: Data bytes fill the buffer at consecutive offsets, starting at the offset held in the low log2(`PAGE_BYTES`) bits of the word address. The offset wraps from the last byte of the page to offset 0. A later byte at the same offset replaces the earlier one, and the upper address bits (the page) never change.
- R6: During the first `PAGE_BYTES` cycles of busy, each buffered offset is written once, in ascending offset order. Each write goes to address {page, offset} and carries the last byte stored there. Offsets that received no byte are not written.
- R7: While `busy_o` is high, write commands, data bytes and STOPs are ignored. They cause no array write and do not extend or restart the busy period.
- R8: `addr_ack_o` follows `addr_match_i` in standby and is low while `busy_o` is high.
- R9: At the end of a cycle the buffer is empty. A STOP following a completed cycle, with no new byte since, starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Pulse: a write command was accepted; `word_addr_i` is valid |
| word_addr_i | input | ADDR_W | Word address of the write command |
| byte_vld_i | input | 1 | Pulse: a data byte was received and acknowledged |
| byte_data_i | input | DATA_W | Data byte value |
| stop_i | input | 1 | Pulse: a STOP condition was seen |
| wp_i | input | 1 | Write protect, high blocks the commit |
| addr_match_i | input | 1 | Front end decoded a matching device address |
| addr_ack_o | output | 1 | Acknowledge permission for the device address |
| busy_o | output | 1 | Timed write cycle in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
A wrong phase state makes `busy_o` and `addr_ack_o` disagree with the STOP history in the cycle right after the STOP. A wrong tick count shows up only when busy drops, as a busy period of the wrong length. A corrupted buffer pointer or valid bit becomes visible only at the next commit burst. It then appears as a write to the wrong address, a missing write, an extra write, or writes in the wrong order, within `PAGE_BYTES` cycles of the STOP. A buffer that is not cleared stays hidden until a later empty STOP starts a cycle it should not.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PROG = 1'b1
  } ewc_state_e;
endpackage

// File: rtl/ewc_page_buf.sv
module ewc_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [OFF_W-1:0]  load_off_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [OFF_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [OFF_W-1:0]      ptr_q;
  logic                  wr_en;

  assign wr_en = push_i && !clear_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (clear_i) begin
      vld_q <= '0;
    end else if (load_i) begin
      vld_q <= '0;
      ptr_q <= load_off_i;
    end else if (push_i) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= ptr_q + 1'b1; // wraps inside the page
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) data_q[ptr_q] <= push_data_i;
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_vld_o = |vld_q;
endmodule

// File: rtl/ewc_timer.sv
module ewc_timer #(
  parameter int TICKS = 625000,
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = run_i && (cnt_q == CNT_W'(TICKS - 1));
endmodule

// File: rtl/eeprom_wr_cycle_ctrl.sv
module eeprom_wr_cycle_ctrl
  import ewc_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_TICKS   = 625000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              addr_match_i,
  output logic              addr_ack_o,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int CNT_W = (WR_TICKS > 1) ? $clog2(WR_TICKS) : 1;

  ewc_state_e        state_q;
  logic [PG_W-1:0]   pg_q;
  logic              idle, commit, discard;
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic [OFF_W-1:0]  scan_idx;
  logic              in_burst;
  logic [DATA_W-1:0] rd_data;
  logic              rd_vld, any_vld;

  assign idle    = (state_q == ST_IDLE);
  assign commit  = idle && stop_i && any_vld && !wp_i;
  assign discard = idle && stop_i && !commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pg_q    <= '0;
    end else begin
      if (idle && cmd_wr_i) pg_q <= word_addr_i[ADDR_W-1:OFF_W];
      case (state_q)
        ST_IDLE: if (commit) state_q <= ST_PROG;
        ST_PROG: if (last)   state_q <= ST_IDLE;
        default:             state_q <= ST_IDLE;
      endcase
    end
  end

  ewc_timer #(.TICKS(WR_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!idle),
    .cnt_o  (cnt),
    .last_o (last)
  );

  // burst reuses the cycle timer as the scan index
  assign scan_idx = cnt[OFF_W-1:0];
  assign in_burst = !idle && (32'(cnt) < PAGE_BYTES);

  ewc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (discard || last),
    .load_i      (idle && cmd_wr_i),
    .load_off_i  (word_addr_i[OFF_W-1:0]),
    .push_i      (idle && byte_vld_i),
    .push_data_i (byte_data_i),
    .rd_idx_i    (scan_idx),
    .rd_data_o   (rd_data),
    .rd_vld_o    (rd_vld),
    .any_vld_o   (any_vld)
  );

  assign busy_o     = !idle;
  assign addr_ack_o = addr_match_i && idle;
  assign arr_we_o   = in_burst && rd_vld;
  assign arr_addr_o = {pg_q, scan_idx};
  assign arr_data_o = rd_data;
endmodule

// File: rtl/ewc_chk.sv
module ewc_chk #(
  parameter int ADDR_W   = 11,
  parameter int WR_TICKS = 625000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              wp_i,
  input logic              addr_match_i,
  input logic              addr_ack_o,
  input logic              busy_o,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o
);
  int unsigned run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_cnt <= 0;
    else if (!busy_o) run_cnt <= 0;
    else              run_cnt <= run_cnt + 1;
  end

  // R1
  we_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);

  // R2
  busy_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  // R2
  busy_len_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_cnt < WR_TICKS);

  // R7
  busy_len_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_cnt == WR_TICKS);

  // R4
  wp_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wp_i && !busy_o) |=> !busy_o);

  // R6
  burst_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o && $past(arr_we_o)) |-> arr_addr_o > $past(arr_addr_o));

  // R8
  ack_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !addr_ack_o);

  // R8
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && addr_match_i) |-> addr_ack_o);
endmodule

bind eeprom_wr_cycle_ctrl ewc_chk #(.ADDR_W(ADDR_W), .WR_TICKS(WR_TICKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_i       (stop_i),
  .wp_i         (wp_i),
  .addr_match_i (addr_match_i),
  .addr_ack_o   (addr_ack_o),
  .busy_o       (busy_o),
  .arr_we_o     (arr_we_o),
  .arr_addr_o   (arr_addr_o)
);

// File: tb/eeprom_wr_cycle_ctrl_bench.sv
module eeprom_wr_cycle_ctrl_bench;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int PAGE   = 16;
  localparam int OFF_W  = 4;
  localparam int TICKS  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, byte_vld = 0, stop = 0, wp = 0, addr_match = 0;
  logic [ADDR_W-1:0] word_addr = '0;
  logic [DATA_W-1:0] byte_data = '0;
  logic addr_ack, busy, arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [ADDR_W+DATA_W-1:0] exp_q[$];
  logic [ADDR_W-OFF_W-1:0]  m_pg = '0;
  logic [OFF_W-1:0]         m_ptr = '0;
  logic [PAGE-1:0]          m_vld = '0;
  logic [DATA_W-1:0]        m_dat [PAGE];

  always #4 clk = ~clk;

  eeprom_wr_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE),
                         .WR_TICKS(TICKS)) u_eeprom_wr_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .word_addr_i(word_addr),
    .byte_vld_i(byte_vld), .byte_data_i(byte_data), .stop_i(stop), .wp_i(wp),
    .addr_match_i(addr_match), .addr_ack_o(addr_ack), .busy_o(busy),
    .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_data_o(arr_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected array writes
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected write", int'({arr_addr, arr_data}), 0);
      end else begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = exp_q.pop_front();
        check({arr_addr, arr_data} == e, "R6 write addr/data", int'({arr_addr, arr_data}), int'(e));
      end
    end
  end

  task automatic do_cmd(input logic [ADDR_W-1:0] a, input bit apply);
    @(negedge clk); cmd_wr = 1; word_addr = a;
    if (apply) begin m_pg = a[ADDR_W-1:OFF_W]; m_ptr = a[OFF_W-1:0]; m_vld = '0; end
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic do_byte(input logic [DATA_W-1:0] d, input bit apply);
    @(negedge clk); byte_vld = 1; byte_data = d;
    if (apply) begin m_dat[m_ptr] = d; m_vld[m_ptr] = 1'b1; m_ptr = m_ptr + 1'b1; end
    @(negedge clk); byte_vld = 0;
  endtask

  // returns whether a cycle is expected
  task automatic do_stop(input bit apply, output bit exp_busy);
    exp_busy = 0;
    @(negedge clk); stop = 1;
    if (apply) begin
      if (!wp && (|m_vld)) begin
        exp_busy = 1;
        for (int i = 0; i < PAGE; i++)
          if (m_vld[i]) exp_q.push_back({m_pg, OFF_W'(i), m_dat[i]});
      end
      m_vld = '0;
    end
    @(negedge clk); stop = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic run_cycle(input string req);
    bit eb; int n;
    do_stop(1, eb);
    check(busy == eb, req, busy, eb);
    wait_idle(n);
    if (eb) check(n == TICKS, "R2 busy length", n, TICKS);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit eb; int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    addr_match = 1; #1;
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(arr_we == 0, "R1 we", arr_we, 0);
    check(addr_ack == 1, "R8 ack idle", addr_ack, 1);
    addr_match = 0;

    // R2 single byte
    do_cmd(11'h123, 1); do_byte(8'hA5, 1);
    run_cycle("R2 byte write busy");
    // R9 empty stop after cycle
    run_cycle("R9 no cycle after commit");

    // R5 partial page from mid offset
    do_cmd(11'h045, 1);
    for (int i = 0; i < 3; i++) do_byte(8'hC0 + 8'(i), 1);
    run_cycle("R5 partial page busy");

    // R5 wrap and overwrite
    do_cmd(11'h7FE, 1);
    for (int i = 0; i < 18; i++) do_byte(8'h10 + 8'(i), 1);
    run_cycle("R5 wrap busy");

    // R3 dummy write then bare stop
    do_cmd(11'h200, 1);
    run_cycle("R3 dummy write no busy");
    run_cycle("R3 bare stop no busy");

    // R4 write protect discards buffer
    wp = 1;
    do_cmd(11'h300, 1); do_byte(8'h11, 1); do_byte(8'h22, 1);
    run_cycle("R4 wp no busy");
    wp = 0;
    run_cycle("R4 discarded no busy");
    do_cmd(11'h310, 1); do_byte(8'h33, 1);
    run_cycle("R4 write after wp");

    // R7 / R8 traffic during busy
    do_cmd(11'h400, 1); do_byte(8'h44, 1);
    do_stop(1, eb);
    check(busy == 1, "R7 busy started", busy, 1);
    addr_match = 1; #1;
    check(addr_ack == 0, "R8 ack blocked busy", addr_ack, 0);
    do_cmd(11'h500, 0); do_byte(8'h55, 0); do_stop(0, eb);
    wait_idle(n);
    check(n + 6 == TICKS, "R7 busy not extended", n + 6, TICKS);
    #1;
    check(addr_ack == 1, "R8 ack after cycle", addr_ack, 1);
    addr_match = 0;
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R7 all writes seen", exp_q.size(), 0);
    run_cycle("R7 ignored bytes not kept");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule